// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block turns one up/down carrier counter into three complementary PWM pairs for a three-phase inverter bridge. The carrier climbs from zero to a programmed period and falls back to zero, advancing once per clock-enable pulse from an external prescaler. Each phase compares the carrier against its own active compare value. That gives a positive drive signal and its complement. Every rising edge of either signal is held back by a programmed dead time, so the two switches of a bridge leg are never on together.

Software writes duty values into buffer registers through a simple write-only configuration port. A buffered value reaches the active comparator only at the carrier trough, which keeps each carrier cycle symmetric. The block raises a one-cycle interrupt pulse at the carrier peak and at the trough, and each of the two can be masked on its own. It also emits a one-cycle A/D start pulse a programmable number of carrier steps after each trough.

Top module: `tpwm_gen`

## Requirements
- R1: While run is set, the carrier moves one step per `tick` cycle. It counts up from 0 to the period value, then down to 0, and repeats. It holds when `tick` is low. Clearing run resets the carrier to 0 counting up and drives all six PWM outputs low. A period of at least 1 is assumed.
- R2: Before dead time, a phase's positive signal is high while carrier < compare, and its negative signal is the complement. Compare 0 keeps the positive output low (0 %). A compare value above the period keeps it high on every carrier step (100 %).
- R3: A rising edge on any of the six outputs appears only after its undelayed signal has stayed high for the dead-time number of further `tick` steps. Falling edges follow at once. `pwm_hi[i]` and `pwm_lo[i]` are never high together.
- R4: If an undelayed signal stays high for no more steps than the dead time, the output stays low for the whole pulse and does not glitch.
- R5: Duty writes go to buffers. A buffer is copied to its active compare on the tick that leaves the trough (down-counting at 0). While stopped, the compare follows the buffer one cycle later. At no other time does the active compare change.
- R6: `irq` pulses for one cycle after a peak tick (up-counting, carrier at or above the period) and after a trough tick. Mask bit 0 suppresses the peak pulse and mask bit 1 suppresses the trough pulse.
- R7: Let D be the A/D delay. `adc_trig` pulses for one cycle after the D-th tick that follows a trough tick, or right after the trough tick when D is 0. D must stay below two periods.
- R8: Configuration map, written on a clock with `cfg_we` high. Address 0 is run (bit 0), 1 is the period, 2 the dead time (low bits), 3 the A/D delay, 4 the interrupt mask (bits 1:0), and 5, 6 and 7 are the duty buffers of phases 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Carrier step enable from prescaler |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | CW | Configuration write data |
| pwm_hi | output | 3 | Positive drive per phase |
| pwm_lo | output | 3 | Negative drive per phase |
| adc_trig | output | 1 | A/D conversion start pulse |
| irq | output | 1 | Peak/trough interrupt pulse |

## Verification
The checks take for granted that the period is never below 1 and that the A/D delay stays below two periods. With a zero period the carrier direction logic would bounce oddly, and with a delay of two periods or more a pending trigger would be cut off by the next trough. The stimulus keeps random periods at 4 or more and random delays at 7 or less. Directed phases still reach the zero and full duty corners, dead times longer than a pulse, and each mask setting. Duty values are drawn up to two above the period, so the 100 % case also shows up at random.

// File: rtl/tpwm_gen.sv
module tpwm_gen #(
  parameter int CW  = 16,
  parameter int DTW = 8,
  parameter int NPH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  output logic [NPH-1:0] pwm_hi,
  output logic [NPH-1:0] pwm_lo,
  output logic          adc_trig,
  output logic          irq
);
  localparam int NOUT = 2 * NPH;

  logic                   run_r;
  logic [CW-1:0]          per_r, adly_r, cnt, acnt;
  logic [DTW-1:0]         dt_r;
  logic [1:0]             mask_r;
  logic [NPH-1:0][CW-1:0] buf_r, cmp_r;
  logic                   up, act;
  logic [NPH-1:0]         raw_hi;
  logic [NOUT-1:0]        raw6, out6;
  logic                   peak_ev, trough_ev;

  // configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_r <= 1'b0; per_r <= '0; dt_r <= '0; adly_r <= '0; mask_r <= '0; buf_r <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: run_r  <= cfg_wdata[0];
        3'd1: per_r  <= cfg_wdata;
        3'd2: dt_r   <= cfg_wdata[DTW-1:0];
        3'd3: adly_r <= cfg_wdata;
        3'd4: mask_r <= cfg_wdata[1:0];
        3'd5: buf_r[0] <= cfg_wdata;
        3'd6: buf_r[1] <= cfg_wdata;
        default: buf_r[2] <= cfg_wdata;
      endcase
    end
  end

  assign peak_ev   = run_r & tick & up & (cnt >= per_r);
  assign trough_ev = run_r & tick & ~up & (cnt == '0);

  // triangle carrier
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; up <= 1'b1;
    end else if (!run_r) begin
      cnt <= '0; up <= 1'b1;
    end else if (tick) begin
      if (up) begin
        if (cnt >= per_r) begin up <= 1'b0; cnt <= cnt - 1'b1; end
        else cnt <= cnt + 1'b1;
      end else begin
        if (cnt == '0) begin up <= 1'b1; cnt <= cnt + 1'b1; end
        else cnt <= cnt - 1'b1;
      end
    end
  end

  assert_bounce_R1: assert property (@(posedge clk) disable iff (!rst_n)
    trough_ev |=> (cnt == CW'(1)));

  // double-buffered compare
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_r <= '0;
    else if (!run_r || trough_ev) cmp_r <= buf_r;
  end

  assert_trough_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trough_ev |=> (cmp_r == $past(buf_r)));
  assert_cmp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_r && !trough_ev) |=> $stable(cmp_r));

  // compare and dead time
  generate
    for (genvar p = 0; p < NPH; p++) begin : g_cmp
      assign raw_hi[p] = cnt < cmp_r[p];
    end
  endgenerate
  assign raw6 = {~raw_hi, raw_hi};

  generate
    for (genvar g = 0; g < NOUT; g++) begin : g_dead
      logic [DTW-1:0] dcnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dcnt <= '0;
        else if (!run_r) dcnt <= '0;
        else if (tick) begin
          if (!raw6[g]) dcnt <= '0;
          else if (dcnt < dt_r) dcnt <= dcnt + 1'b1;
        end
      end
      assign out6[g] = run_r & raw6[g] & (dcnt >= dt_r);

      assert_rise_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out6[g]) && dt_r != '0 && $stable(dt_r)) |-> $past(raw6[g]));
    end
  endgenerate

  assign pwm_hi = out6[NPH-1:0];
  assign pwm_lo = out6[NOUT-1:NPH];

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_hi & pwm_lo) == '0);
  assert_stopped_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_r |-> (pwm_hi == '0 && pwm_lo == '0));

  // interrupt
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else irq <= (peak_ev & ~mask_r[0]) | (trough_ev & ~mask_r[1]);
  end

  assert_peak_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (peak_ev && mask_r[0]) |=> !irq);
  assert_trough_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trough_ev && mask_r[1]) |=> !irq);

  // delayed A/D trigger
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adc_trig <= 1'b0; act <= 1'b0; acnt <= '0;
    end else if (!run_r) begin
      adc_trig <= 1'b0; act <= 1'b0;
    end else begin
      adc_trig <= 1'b0;
      if (trough_ev) begin
        if (adly_r == '0) adc_trig <= 1'b1;
        else begin act <= 1'b1; acnt <= adly_r; end
      end else if (tick && act) begin
        if (acnt == CW'(1)) begin adc_trig <= 1'b1; act <= 1'b0; end
        else acnt <= acnt - 1'b1;
      end
    end
  end

  assert_adc_nodelay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trough_ev && adly_r == '0) |=> adc_trig);
endmodule

// File: tb/tpwm_gen_bench.sv
module tpwm_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic [2:0] pwm_hi, pwm_lo;
  logic adc_trig, irq;

  tpwm_gen u_tpwm_gen (.clk(clk), .rst_n(rst_n), .tick(tick), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .adc_trig(adc_trig), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, tick_pct = 100;
  bit done = 0;
  string tag = "R1";

  // reference model, state after the last clock edge
  bit m_run, m_up, m_act, m_irq, m_trig;
  int m_cnt, m_per, m_dt, m_adly, m_acnt, m_mask;
  int m_buf[3], m_cmp[3], m_d[6];

  function automatic bit m_raw(int i);
    bit h = m_cnt < m_cmp[i % 3];
    return (i < 3) ? h : !h;
  endfunction

  function automatic bit m_out(int i);
    return m_run && m_raw(i) && (m_d[i] >= m_dt);
  endfunction

  task automatic m_step(bit tk, bit we, int a, int dv);
    bit pk, tr;
    bit rw[6];
    pk = m_run && tk && m_up && (m_cnt >= m_per);
    tr = m_run && tk && !m_up && (m_cnt == 0);
    for (int i = 0; i < 6; i++) rw[i] = m_raw(i);
    m_irq = (pk && !m_mask[0]) || (tr && !m_mask[1]);
    m_trig = 0;
    if (!m_run) m_act = 0;
    else if (tr) begin
      if (m_adly == 0) m_trig = 1; else begin m_act = 1; m_acnt = m_adly; end
    end else if (tk && m_act) begin
      if (m_acnt == 1) begin m_trig = 1; m_act = 0; end else m_acnt--;
    end
    for (int i = 0; i < 6; i++) begin
      if (!m_run) m_d[i] = 0;
      else if (tk) m_d[i] = !rw[i] ? 0 : (m_d[i] < m_dt ? m_d[i] + 1 : m_d[i]);
    end
    if (!m_run || tr) for (int i = 0; i < 3; i++) m_cmp[i] = m_buf[i];
    if (!m_run) begin m_cnt = 0; m_up = 1; end
    else if (tk) begin
      if (m_up) begin
        if (m_cnt >= m_per) begin m_up = 0; m_cnt--; end else m_cnt++;
      end else begin
        if (m_cnt == 0) begin m_up = 1; m_cnt++; end else m_cnt--;
      end
    end
    if (we) case (a)
      0: m_run = dv[0];
      1: m_per = dv;
      2: m_dt = dv & 8'hff;
      3: m_adly = dv;
      4: m_mask = dv & 3;
      default: m_buf[a-5] = dv;
    endcase
  endtask

  task automatic chk(string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  bit seen_hi0;

  task automatic compare();
    int eh = 0, el = 0;
    for (int i = 0; i < 3; i++) begin
      eh[i] = m_out(i);
      el[i] = m_out(i + 3);
    end
    chk("pwm_hi", int'(pwm_hi), eh);
    chk("pwm_lo", int'(pwm_lo), el);
    chk("irq", int'(irq), int'(m_irq));
    chk("adc_trig", int'(adc_trig), int'(m_trig));
    seen_hi0 |= pwm_hi[0];
  endtask

  task automatic cycle(bit we, int a, int dv);
    bit tk;
    @(negedge clk);
    compare();
    tk = ($urandom_range(99) < tick_pct);
    tick = tk; cfg_we = we; cfg_addr = a[2:0]; cfg_wdata = dv[CW-1:0];
    m_step(tk, we, a, dv);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cycle(0, 0, 0);
  endtask

  task automatic wr(int a, int dv);
    cycle(1, a, dv);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd4242));
    m_up = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    @(negedge clk);
    chk("reset outputs", int'({pwm_hi, pwm_lo, irq, adc_trig}), 0);

    // R8 configuration and R2 basic operation
    tag = "R2";
    wr(1, 20); wr(5, 5); wr(6, 10); wr(7, 15); wr(2, 2); wr(3, 3); wr(4, 0); wr(0, 1);
    idle(300);

    // R1 irregular prescaler enable
    tag = "R1"; tick_pct = 50;
    idle(300);

    // R5 duty writes mid-cycle
    tag = "R5"; tick_pct = 100;
    for (int k = 0; k < 20; k++) begin
      wr(5 + $urandom_range(2), $urandom_range(22));
      idle($urandom_range(40, 10));
    end

    // R2 zero and full duty
    tag = "R2";
    wr(2, 0); wr(5, 0); wr(6, 21); wr(7, 20);
    idle(200);

    // R4 pulses shorter than the dead time
    tag = "R4";
    wr(2, 8); wr(5, 3); wr(6, 19);
    idle(100);
    seen_hi0 = 0;
    idle(200);
    chk("short pulse suppressed pwm_hi0", int'(seen_hi0), 0);

    // R3 long dead time on wide pulses
    tag = "R3";
    wr(2, 5); wr(5, 12); wr(6, 6);
    idle(200);

    // R6 interrupt masks
    tag = "R6";
    for (int m = 1; m < 4; m++) begin wr(4, m); idle(150); end
    wr(4, 0);

    // R7 trigger delays
    tag = "R7";
    wr(3, 0); idle(150);
    wr(3, 7); idle(150);
    wr(3, 39); idle(150);

    // mixed random configuration
    tag = "R8"; tick_pct = 70;
    for (int k = 0; k < 60; k++) begin
      int a = $urandom_range(7, 1);
      int dv;
      case (a)
        1: dv = $urandom_range(40, 4);
        2: dv = $urandom_range(6);
        3: dv = $urandom_range(7);
        4: dv = $urandom_range(3);
        default: dv = $urandom_range(42);
      endcase
      wr(a, dv);
      idle($urandom_range(30, 5));
    end

    // R1 stop
    tag = "R1";
    wr(0, 0);
    idle(20);
    chk("stopped outputs", int'({pwm_hi, pwm_lo}), 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
    end
  end
endmodule